// File: doc/BRIEF.md
# Read Data Glitch Filter

This block cleans the squared-up read data stream of a disk drive before it reaches the host. The raw comparator level enters asynchronously. It passes through a synchronizer, and then every edge of it, rising or falling, starts a qualification timer. When the timer runs out, the current synchronized level is sampled and becomes the filtered output. An edge that arrives while the timer runs restarts it. A noise pulse and its return edge therefore leave the output untouched, and a new level reaches the output only after it has stayed put for the whole window.

The window length is given in clock cycles. There is one parameter for the narrow-spacing recording mode (`MFM_WIN`, about 3 us) and one for the dense group-coded mode (`GCR_WIN`, about 1.3 us). The `mode_gcr_i` input picks between them, and its value is taken each time the timer is started. The filtered level is sent to the host only while the drive is selected.

Top module: `rd_glitch_filter`

## Requirements
- R1: `raw_i` passes through two flops. A level that is accepted appears on `filt_o` on the (W+2)th rising clock edge after the edge that first captures it, where W is the active window.
- R2: While reset is held and just after it is released, `filt_o` and `rd_data_o` are 0, no qualification is pending, and `filt_o` stays 0 while `raw_i` stays 0.
- R3: With `mode_gcr_i`=0 (W=`MFM_WIN`), a level held for `MFM_WIN` cycles or fewer is rejected. A level held for `MFM_WIN`+1 cycles or more is accepted.
- R4: With `mode_gcr_i`=1 (W=`GCR_WIN`), a level held for `GCR_WIN` cycles or fewer is rejected. A level held for `GCR_WIN`+1 cycles or more is accepted.
- R5: Rising and falling changes are qualified in the same way, so both a 0-to-1 and a 1-to-0 change of `filt_o` need the full window.
- R6: An edge that arrives while the timer runs restarts the window. A glitch, or a burst of glitches, that ends at the level already on `filt_o` causes no change of `filt_o`.
- R7: `filt_o` changes only when the timer expires. It takes the synchronized level present at that moment, so after a sequence of short pulses it settles on the last level that was held for more than W cycles.
- R8: `rd_data_o` is 0 whenever `sel_i`=0 and equals `filt_o` whenever `sel_i`=1, with no clock delay.
- R9: The window is chosen from `mode_gcr_i` when the timer starts or restarts. A change of `mode_gcr_i` while the timer runs does not alter the running window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raw_i | input | 1 | Raw squared read level from the comparator, asynchronous |
| mode_gcr_i | input | 1 | Window select: 0 selects `MFM_WIN`, 1 selects `GCR_WIN` |
| sel_i | input | 1 | Drive selected |
| filt_o | output | 1 | Filtered read level |
| rd_data_o | output | 1 | Filtered level gated by drive select |

## Verification
A timer that reloads wrongly or counts one cycle too few shows up at the ports in two ways. Pulses of exactly W cycles leak through, and accepted changes land one cycle early. The bench therefore checks the exact cycle of every `filt_o` change against the R1 latency and places pulses at W and W+1 cycles. A lost restart, or a sample taken from a stale level, gives an output change that was never expected, or a wrong value, within W+3 cycles of the offending edge. The monitor flags any change that is not in its queue.

// File: rtl/rgf_pkg.sv
package rgf_pkg;
  typedef enum logic {
    MODE_MFM = 1'b0,
    MODE_GCR = 1'b1
  } rec_mode_e;
endpackage

// File: rtl/rgf_sync.sv
module rgf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rgf_edge.sv
module rgf_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  // either polarity
  assign edge_o = lvl_i ^ prev_q;
endmodule

// File: rtl/rgf_timer.sv
module rgf_timer
  import rgf_pkg::*;
#(
  parameter int MFM_WIN = 750,
  parameter int GCR_WIN = 325
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  rec_mode_e mode_i,
  output logic      busy_o,
  output logic      expire_o
);
  localparam int MAX_WIN = (MFM_WIN > GCR_WIN) ? MFM_WIN : GCR_WIN;
  localparam int CNT_W   = $clog2(MAX_WIN + 1);
  localparam logic [CNT_W-1:0] MFM_LD = CNT_W'(MFM_WIN - 1);
  localparam logic [CNT_W-1:0] GCR_LD = CNT_W'(GCR_WIN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      // window latched at (re)start
      cnt_q  <= (mode_i == MODE_GCR) ? GCR_LD : MFM_LD;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign expire_o = busy_q && (cnt_q == '0) && !start_i;
endmodule

// File: rtl/rd_glitch_filter.sv
module rd_glitch_filter
  import rgf_pkg::*;
#(
  parameter int MFM_WIN     = 750,
  parameter int GCR_WIN     = 325,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  input  logic mode_gcr_i,
  input  logic sel_i,
  output logic filt_o,
  output logic rd_data_o
);
  logic      sync_lvl;
  logic      edge_p;
  logic      busy;
  logic      expire;
  logic      filt_q;
  rec_mode_e mode;

  assign mode = rec_mode_e'(mode_gcr_i);

  rgf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (sync_lvl)
  );

  rgf_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sync_lvl),
    .edge_o(edge_p)
  );

  rgf_timer #(.MFM_WIN(MFM_WIN), .GCR_WIN(GCR_WIN)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (edge_p),
    .mode_i  (mode),
    .busy_o  (busy),
    .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     filt_q <= 1'b0;
    else if (expire) filt_q <= sync_lvl;
  end

  assign filt_o    = filt_q;
  assign rd_data_o = filt_q & sel_i;
endmodule

// File: rtl/rgf_chk.sv
module rgf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic sel_i,
  input logic rd_data_o,
  input logic filt_o,
  input logic edge_p,
  input logic busy,
  input logic expire
);
  // R8
  deselect_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |-> !rd_data_o);

  // R7
  change_on_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_o) |-> $past(expire));

  // R6
  edge_arms_timer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_p |=> busy);

  // R6
  expire_ends_timer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> !busy);

  // R2
  idle_no_expire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !edge_p) |=> !expire);
endmodule

bind rd_glitch_filter rgf_chk u_chk (.*);

// File: tb/sim_rd_glitch_filter.sv
`timescale 1ns/1ps
module sim_rd_glitch_filter;
  localparam int MFM_W = 750;
  localparam int GCR_W = 325;

  typedef struct {
    logic  val;
    int    cyc;
    string req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic raw = 1'b0;
  logic mode_gcr = 1'b0;
  logic sel = 1'b0;
  logic filt, rd_data;

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  logic acc = 1'b0;
  logic last_filt = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rd_glitch_filter #(.MFM_WIN(MFM_W), .GCR_WIN(GCR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw), .mode_gcr_i(mode_gcr),
    .sel_i(sel), .filt_o(filt), .rd_data_o(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive level v for hold cycles; push expected change if it qualifies
  task automatic drive_level(input logic v, input int hold, input logic gcr, input string req);
    int win;
    exp_t e;
    @(negedge clk);
    win = gcr ? GCR_W : MFM_W;
    mode_gcr = gcr;
    raw = v;
    if (hold > win && v != acc) begin
      e.val = v; e.cyc = cyc + win + 3; e.req = req;
      q.push_back(e);
      acc = v;
    end
    repeat (hold - 1) @(negedge clk);
  endtask

  // monitor: every change of filt must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && filt !== last_filt) begin
      if (q.size() == 0) begin
        check(1'b0, "R6 unexpected change", int'(filt), int'(last_filt));
      end else begin
        exp_t e;
        e = q.pop_front();
        check(filt === e.val, {e.req, " value"}, int'(filt), int'(e.val));
        check(cyc == e.cyc, {e.req, " cycle (R1)"}, cyc, e.cyc);
      end
      last_filt = filt;
    end
  end

  task automatic expect_level(input logic v, input string req);
    @(negedge clk);
    check(filt === v && q.size() == 0, req, int'(filt), int'(v));
  endtask

  initial begin
    repeat (600000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    exp_t e;
    int t0;
    repeat (3) @(negedge clk);
    check(filt === 1'b0 && rd_data === 1'b0, "R2 reset outputs", int'(filt), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(filt === 1'b0, "R2 idle after reset", int'(filt), 0);

    // R3 boundaries in MFM mode
    drive_level(1'b1, MFM_W, 1'b0, "R3");
    drive_level(1'b0, MFM_W + 20, 1'b0, "R3");
    expect_level(1'b0, "R3 pulse of W rejected");
    drive_level(1'b1, MFM_W + 1, 1'b0, "R3");
    drive_level(1'b0, 1, 1'b0, "R3");
    drive_level(1'b1, MFM_W + 20, 1'b0, "R3");
    expect_level(1'b1, "R3 W+1 accepted");

    // R8 select gating
    @(negedge clk); sel = 1'b0; #1;
    check(rd_data === 1'b0, "R8 deselected", int'(rd_data), 0);
    sel = 1'b1; #1;
    check(rd_data === filt, "R8 selected", int'(rd_data), int'(filt));

    // R5 falling change
    drive_level(1'b0, MFM_W, 1'b0, "R5");
    drive_level(1'b1, MFM_W + 20, 1'b0, "R5");
    expect_level(1'b1, "R5 low pulse of W rejected");
    drive_level(1'b0, MFM_W + 20, 1'b0, "R5");
    expect_level(1'b0, "R5 falling accepted");
    #1 check(rd_data === 1'b0, "R8 follows low", int'(rd_data), 0);

    // R4 boundaries in GCR mode
    drive_level(1'b1, GCR_W, 1'b1, "R4");
    drive_level(1'b0, GCR_W + 20, 1'b1, "R4");
    expect_level(1'b0, "R4 pulse of W rejected");
    drive_level(1'b1, GCR_W + 1, 1'b1, "R4");
    drive_level(1'b0, GCR_W + 20, 1'b1, "R4");
    expect_level(1'b0, "R4 W+1 then back");

    // R6 burst of glitches ending at current level
    for (int i = 0; i < 6; i++) begin
      drive_level(1'b1, 100 + i * 20, 1'b0, "R6");
      drive_level(1'b0, 50, 1'b0, "R6");
    end
    drive_level(1'b0, MFM_W + 20, 1'b0, "R6");
    expect_level(1'b0, "R6 burst rejected");

    // R7 short pulses, then a long level
    drive_level(1'b1, 200, 1'b0, "R7");
    drive_level(1'b0, 60, 1'b0, "R7");
    drive_level(1'b1, MFM_W + 40, 1'b0, "R7");
    expect_level(1'b1, "R7 settles high");
    drive_level(1'b0, 300, 1'b1, "R7");
    drive_level(1'b1, 30, 1'b1, "R7");
    drive_level(1'b0, GCR_W + 40, 1'b1, "R7");
    expect_level(1'b0, "R7 settles low");

    // R9 window latched at start: GCR window, mode flips to MFM mid-run
    @(negedge clk);
    mode_gcr = 1'b1; raw = 1'b1; t0 = cyc;
    e.val = 1'b1; e.cyc = t0 + GCR_W + 3; e.req = "R9";
    q.push_back(e); acc = 1'b1;
    repeat (10) @(negedge clk);
    mode_gcr = 1'b0;
    repeat (GCR_W + 30) @(negedge clk);
    expect_level(1'b1, "R9 running window kept");
    // MFM window latched, mode flips to GCR mid-run: GCR-length pulse is not accepted
    @(negedge clk);
    mode_gcr = 1'b0; raw = 1'b0;
    repeat (10) @(negedge clk);
    mode_gcr = 1'b1;
    repeat (GCR_W + 20) @(negedge clk);
    raw = 1'b1;
    repeat (MFM_W + 20) @(negedge clk);
    expect_level(1'b1, "R9 MFM window kept");

    repeat (20) @(negedge clk);
    check(q.size() == 0, "R1 queue drained", q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule